// File: doc/BRIEF.md
# Addressable Switch Command Controller

This block is the function layer of a single-wire slave device. The device holds a 64-bit identity and drives one open-drain output. A bit-level front end, which is not part of this block, decodes the line timing. It passes in a one-cycle strobe for each bit the master writes and a one-cycle strobe for each read slot the master opens. It also passes in a pulse when it sees a line reset. The controller answers each read slot with a registered response bit. A response of 1 leaves the line released.

After every line reset, the controller first collects an 8-bit command, least significant bit first. It then runs one of the following sequences:
- identity read-out;
- 64-bit match, which toggles the output control flip-flop;
- search, which reports the output pin level;
- active-only search, which only a device whose pulldown is on joins;
- skip, which leaves the device silent until the next reset.

After a completed match or search, every further read slot reports the output state until the next reset. The external output pin is sampled through a synchronizer, so the reported level is the real pin level and not a copy of the control bit. A long-low line condition is signalled separately. It clears the control flip-flop as well as the sequence.

Top module: `swc_switch_ctrl`

## Requirements
- R1: After `rst`, `out_ctl` is 0 (pulldown off) and `rd_bit` is 1.
- R2: The command is the first 8 written bits after a reset, taken least significant bit first. Read slots answered before the command is complete return 1.
- R3: Command 8'h33 returns the 64 identity bits on successive read slots, bit 0 first. Every later read slot returns 1.
- R4: Command 8'h55 followed by 64 written bits equal to the identity (bit 0 first) toggles `out_ctl` right after the 64th bit. Every later read slot returns the synchronized `pin_in` level.
- R5: In a match, one written bit that differs from the identity leaves `out_ctl` unchanged. Every later read slot returns 1.
- R6: Command 8'hF0 runs one triple per identity bit: the first read returns the bit, the second read returns its complement, and the written bit is then compared. A completed search leaves `out_ctl` unchanged. Later reads return the synchronized `pin_in` level.
- R7: In a search, a written bit that differs from the identity bit drops the device out. All later read slots return 1.
- R8: Command 8'hEC behaves as R6 only when `out_ctl` is 1, and its completed reads return 0 (the inverse of control). When `out_ctl` is 0, the device takes no part and every read returns 1.
- R9: Command 8'hCC and any unrecognised code make every read return 1 until the next reset. Writes made in that state leave `out_ctl` unchanged.
- R10: `line_reset` restarts command reception and keeps `out_ctl`. `line_lost` does the same and also clears `out_ctl` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| line_reset | input | 1 | Pulse: line reset detected by the front end |
| line_lost | input | 1 | Pulse: line held low long enough to drop the output |
| wr_stb | input | 1 | Pulse: one bit written by the master |
| wr_bit | input | 1 | Value of the written bit |
| rd_stb | input | 1 | Pulse: read slot opened by the master |
| rd_bit | output | 1 | Registered read-slot response, updated one cycle after `rd_stb` (1 = release) |
| dev_id | input | 64 | Fixed device identity, bit 0 sent first |
| pin_in | input | 1 | Sensed level of the open-drain output pin |
| out_ctl | output | 1 | Output control flip-flop (1 = pulldown on) |

## Verification
The hardest case to reach is the one where the reported pin level differs from the control bit. A search report and an active-only report then give opposite answers for the same device. The bench reaches it by overriding its pin model to mimic a shorted pin while the control is on, then running both searches to completion. A second hard case is a drop-out deep inside a 64-bit match or search. Random identities with a check byte, together with random deviation positions (including bit 63), reach it.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int ID_W  = 64;
  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CMD_READ_ID  = 8'h33;
  localparam logic [CMD_W-1:0] CMD_MATCH    = 8'h55;
  localparam logic [CMD_W-1:0] CMD_SEARCH   = 8'hF0;
  localparam logic [CMD_W-1:0] CMD_SEARCH_A = 8'hEC;
  localparam logic [CMD_W-1:0] CMD_SKIP     = 8'hCC;

  typedef enum logic [2:0] {
    ST_CMD    = 3'd0,
    ST_READID = 3'd1,
    ST_MATCH  = 3'd2,
    ST_SRCH   = 3'd3,
    ST_REPORT = 3'd4,
    ST_IDLE   = 3'd5
  } swc_state_t;

  typedef enum logic [1:0] {
    PH_BIT  = 2'd0,
    PH_COMP = 2'd1,
    PH_WR   = 2'd2
  } swc_phase_t;
endpackage

// File: rtl/swc_cmd_shift.sv
module swc_cmd_shift #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [CMD_W-1:0] cmd_next,
  output logic             last
);
  localparam int CW = $clog2(CMD_W);

  logic [CMD_W-1:0] sreg;
  logic [CW-1:0]    cnt;

  // bit 0 arrives first; new bits enter at the top and move down
  assign cmd_next = {bit_in, sreg[CMD_W-1:1]};
  assign last     = (cnt == CW'(CMD_W-1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (shift_en) begin
      sreg <= cmd_next;
      cnt  <= last ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/swc_id_walker.sv
module swc_id_walker #(
  parameter int ID_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            advance,
  input  logic [ID_W-1:0] id_in,
  output logic            cur_bit,
  output logic            last
);
  localparam int IW = $clog2(ID_W);

  logic [IW-1:0] idx;

  assign cur_bit = id_in[idx];
  assign last    = (idx == IW'(ID_W-1));

  always_ff @(posedge clk) begin
    if (rst || clear) idx <= '0;
    else if (advance) idx <= last ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/swc_pin_ctl.sv
module swc_pin_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_ctl,
  input  logic toggle,
  input  logic pin_in,
  output logic ctl,
  output logic pin_sync
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst || clear_ctl) ctl <= 1'b0;
    else if (toggle)      ctl <= ~ctl;
  end

  // released pin reads high, so the chain resets to 1
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b1;
          else     sync_q[0] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[i] <= 1'b1;
          else     sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign pin_sync = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/swc_switch_ctrl.sv
module swc_switch_ctrl
  import swc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_reset,
  input  logic            line_lost,
  input  logic            wr_stb,
  input  logic            wr_bit,
  input  logic            rd_stb,
  output logic            rd_bit,
  input  logic [ID_W-1:0] dev_id,
  input  logic            pin_in,
  output logic            out_ctl
);
  swc_state_t       state;
  swc_phase_t       phase;
  logic             active_q;
  logic             clear_seq;
  logic [CMD_W-1:0] cmd_next;
  logic             cmd_last;
  logic             cmd_done;
  logic             id_bit;
  logic             id_last;
  logic             step;
  logic             toggle;
  logic             pin_sync;
  logic             resp;

  assign clear_seq = line_reset | line_lost;
  assign cmd_done  = (state == ST_CMD) && wr_stb && cmd_last;

  always_comb begin
    step = 1'b0;
    unique case (state)
      ST_READID: step = rd_stb;
      ST_MATCH:  step = wr_stb;
      ST_SRCH:   step = wr_stb && (phase == PH_WR);
      default:   step = 1'b0;
    endcase
  end

  assign toggle = (state == ST_MATCH) && wr_stb && (wr_bit == id_bit) && id_last && !clear_seq;

  always_comb begin
    resp = 1'b1;
    unique case (state)
      ST_READID: resp = id_bit;
      ST_SRCH: begin
        if (phase == PH_BIT)       resp = id_bit;
        else if (phase == PH_COMP) resp = ~id_bit;
        else                       resp = 1'b1;
      end
      ST_REPORT: resp = active_q ? ~out_ctl : pin_sync;
      default:   resp = 1'b1;
    endcase
  end

  swc_cmd_shift #(.CMD_W(CMD_W)) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear_seq),
    .shift_en ((state == ST_CMD) && wr_stb),
    .bit_in   (wr_bit),
    .cmd_next (cmd_next),
    .last     (cmd_last)
  );

  swc_id_walker #(.ID_W(ID_W)) u_walk (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear_seq | cmd_done),
    .advance (step),
    .id_in   (dev_id),
    .cur_bit (id_bit),
    .last    (id_last)
  );

  swc_pin_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk       (clk),
    .rst       (rst),
    .clear_ctl (line_lost),
    .toggle    (toggle),
    .pin_in    (pin_in),
    .ctl       (out_ctl),
    .pin_sync  (pin_sync)
  );

  always_ff @(posedge clk) begin
    if (rst || clear_seq) begin
      state    <= ST_CMD;
      phase    <= PH_BIT;
      active_q <= 1'b0;
      rd_bit   <= 1'b1;
    end else begin
      if (rd_stb) rd_bit <= resp;
      unique case (state)
        ST_CMD: begin
          if (cmd_done) begin
            phase <= PH_BIT;
            unique case (cmd_next)
              CMD_READ_ID: state <= ST_READID;
              CMD_MATCH:   state <= ST_MATCH;
              CMD_SEARCH: begin
                state    <= ST_SRCH;
                active_q <= 1'b0;
              end
              CMD_SEARCH_A: begin
                state    <= out_ctl ? ST_SRCH : ST_IDLE;
                active_q <= 1'b1;
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
        ST_READID: begin
          if (rd_stb && id_last) state <= ST_IDLE;
        end
        ST_MATCH: begin
          if (wr_stb) begin
            if (wr_bit != id_bit) state <= ST_IDLE;
            else if (id_last)     state <= ST_REPORT;
          end
        end
        ST_SRCH: begin
          if (rd_stb && phase == PH_BIT)       phase <= PH_COMP;
          else if (rd_stb && phase == PH_COMP) phase <= PH_WR;
          else if (wr_stb && phase == PH_WR) begin
            phase <= PH_BIT;
            if (wr_bit != id_bit) state <= ST_IDLE;
            else if (id_last)     state <= ST_REPORT;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/swc_switch_checker.sv
module swc_switch_checker
  import swc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       line_reset,
  input logic       line_lost,
  input logic       wr_stb,
  input logic       rd_stb,
  input logic       rd_bit,
  input logic       out_ctl,
  input swc_state_t state,
  input logic       active_q
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!out_ctl && rd_bit));

  p_rd_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (!rd_stb && !line_reset && !line_lost) |=> $stable(rd_bit));

  p_ctl_only_by_write_r4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(out_ctl)) |-> ($past(wr_stb) || $past(line_lost)));

  p_idle_releases_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && rd_stb && !line_reset && !line_lost) |=> rd_bit);

  p_active_report_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REPORT && active_q && rd_stb && !line_reset && !line_lost) |=> !rd_bit);

  p_lost_clears_r10: assert property (@(posedge clk) disable iff (rst)
    line_lost |=> !out_ctl);

  p_reset_releases_r10: assert property (@(posedge clk) disable iff (rst)
    line_reset |=> (rd_bit && state == ST_CMD));
endmodule

bind swc_switch_ctrl swc_switch_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .line_reset (line_reset),
  .line_lost  (line_lost),
  .wr_stb     (wr_stb),
  .rd_stb     (rd_stb),
  .rd_bit     (rd_bit),
  .out_ctl    (out_ctl),
  .state      (state),
  .active_q   (active_q)
);

// File: tb/swc_switch_ctrl_test.sv
module swc_switch_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_reset = 1'b0;
  logic        line_lost = 1'b0;
  logic        wr_stb = 1'b0;
  logic        wr_bit = 1'b0;
  logic        rd_stb = 1'b0;
  logic        rd_bit;
  logic [63:0] dev_id = 64'h0;
  logic        pin_in;
  logic        out_ctl;

  logic        force_en = 1'b0;
  logic        force_val = 1'b0;
  logic        ctl_m = 1'b0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  // open-drain pin model: pulled low when control is on unless overridden
  assign pin_in = force_en ? force_val : ~out_ctl;

  swc_switch_ctrl uut (
    .clk(clk), .rst(rst), .line_reset(line_reset), .line_lost(line_lost),
    .wr_stb(wr_stb), .wr_bit(wr_bit), .rd_stb(rd_stb), .rd_bit(rd_bit),
    .dev_id(dev_id), .pin_in(pin_in), .out_ctl(out_ctl)
  );

  function automatic logic [7:0] crc8(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [63:0] make_id(input logic [47:0] serial);
    logic [55:0] low = {serial, 8'h05};
    return {crc8(low), low};
  endfunction

  function automatic logic pin_exp();
    return force_en ? force_val : ~ctl_m;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic b);
    @(negedge clk); wr_stb = 1'b1; wr_bit = b;
    @(negedge clk); wr_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(output logic r);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0; r = rd_bit;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_rst();
    @(negedge clk); line_reset = 1'b1;
    @(negedge clk); line_reset = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    bus_rst();
    for (int i = 0; i < 8; i++) wr(c[i]);
  endtask

  task automatic do_readid();
    logic [63:0] got;
    logic r;
    send_cmd(8'h33);
    for (int i = 0; i < 64; i++) begin rd(r); got[i] = r; end
    chk("R3 identity stream", got, dev_id);
    rd(r);
    chk("R3 read after identity", {63'd0, r}, 64'd1);
  endtask

  task automatic do_match(input int flip);
    logic r;
    send_cmd(8'h55);
    for (int i = 0; i < 64; i++) wr((i == flip) ? ~dev_id[i] : dev_id[i]);
    if (flip < 0) ctl_m = ~ctl_m;
    repeat (4) @(negedge clk);
    chk(flip < 0 ? "R4 match toggles" : "R5 mismatch keeps control", {63'd0, out_ctl}, {63'd0, ctl_m});
    rd(r);
    if (flip < 0) chk("R4 report pin", {63'd0, r}, {63'd0, pin_exp()});
    else          chk("R5 mismatch reads 1", {63'd0, r}, 64'd1);
  endtask

  task automatic do_search(input bit active, input int dev);
    logic a, b, r, w;
    logic alive;
    int   bad = 0;
    logic ctl_before = ctl_m;
    logic part = !active || ctl_m;
    alive = part;
    send_cmd(active ? 8'hEC : 8'hF0);
    for (int i = 0; i < 64; i++) begin
      rd(a); rd(b);
      if (alive && (a !== dev_id[i] || b !== ~dev_id[i])) bad++;
      if (!alive && (a !== 1'b1 || b !== 1'b1)) bad++;
      w = (i == dev) ? ~dev_id[i] : dev_id[i];
      wr(w);
      if (w != dev_id[i]) alive = 1'b0;
    end
    if (!part)           chk("R8 inactive device silent", bad, 0);
    else if (dev >= 0)   chk("R7 drop-out triples", bad, 0);
    else                 chk(active ? "R8 active triples" : "R6 search triples", bad, 0);
    chk("R6 search keeps control", {63'd0, out_ctl}, {63'd0, ctl_before});
    rd(r);
    if (!alive)      chk(part ? "R7 dropped reads 1" : "R8 inactive reads 1", {63'd0, r}, 64'd1);
    else if (active) chk("R8 active report 0", {63'd0, r}, 64'd0);
    else             chk("R6 search report pin", {63'd0, r}, {63'd0, pin_exp()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic r;
    void'($urandom(32'd2405));
    dev_id = make_id(48'h1234_5678_9ABC);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset control", {63'd0, out_ctl}, 64'd0);
    chk("R1 reset response", {63'd0, rd_bit}, 64'd1);

    // R2: read before the command finishes returns 1, LSB-first decode
    bus_rst();
    wr(1'b1); wr(1'b1);
    rd(r);
    chk("R2 read during command", {63'd0, r}, 64'd1);
    for (int i = 2; i < 8; i++) wr(i == 4 || i == 5);  // completes 8'h33
    rd(r);
    chk("R2 LSB-first command decode", {63'd0, r}, {63'd0, dev_id[0]});

    do_readid();
    do_match(-1);
    do_match(-1);
    do_match(63);
    do_match(0);
    do_search(1'b0, -1);
    do_search(1'b0, 17);
    do_search(1'b1, -1);           // control off: not participating
    do_match(-1);                  // control on
    do_search(1'b1, -1);
    do_search(1'b1, 63);

    // shorted pin: search reports the pin, active-only reports control
    force_en = 1'b1; force_val = 1'b1;
    repeat (4) @(negedge clk);
    do_search(1'b0, -1);
    do_search(1'b1, -1);
    force_en = 1'b0;

    // R9: skip and unknown codes, with matching writes afterwards
    send_cmd(8'hCC);
    for (int i = 0; i < 64; i++) wr(dev_id[i]);
    rd(r);
    chk("R9 skip reads 1", {63'd0, r}, 64'd1);
    chk("R9 skip keeps control", {63'd0, out_ctl}, {63'd0, ctl_m});
    send_cmd(8'h5A);
    rd(r);
    chk("R9 unknown reads 1", {63'd0, r}, 64'd1);

    // R10
    bus_rst();
    chk("R10 line reset keeps control", {63'd0, out_ctl}, {63'd0, ctl_m});
    @(negedge clk); line_lost = 1'b1;
    @(negedge clk); line_lost = 1'b0;
    ctl_m = 1'b0;
    chk("R10 line lost clears control", {63'd0, out_ctl}, 64'd0);
    do_readid();

    // random mix
    for (int it = 0; it < 24; it++) begin
      int op  = $urandom_range(0, 4);
      int pos = ($urandom_range(0, 1) == 0) ? -1 : $urandom_range(0, 63);
      dev_id = make_id({$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF);
      case (op)
        0: do_readid();
        1, 2: do_match(pos);
        3: do_search(1'b0, pos);
        default: do_search(1'b1, pos);
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule